// File: doc/BRIEF.md
# Banked GPIO Port Controller

A memory-mapped general-purpose I/O port for a parameterised number of pins, where each group of 32 pins forms one bank. A plain register bus carries a word address, a write strobe, a read strobe, 32 bits of write data and 32 bits of read data. Through it software reaches four register groups. Each group is a contiguous array of one 32-bit word per bank. The groups are a read-only pin-level word, a read/write direction word, a write-only set word and a write-only clear word.

The set and clear words change the output latch bit by bit. Software can therefore drive one pin high or low without reading the latch first, and a concurrent update to another pin of the same bank is never lost. The block drives the latch onto `pad_out` and the direction bits onto `pad_oe`. It passes `pad_in` through a chain of synchronising flops, two by default, before the level word presents it. A pin's word is its pin number divided by 32. Its bit is the pin number modulo 32.

Top module: `gpio_bank_port`

## Requirements
- R1: While `rst` is high and after it is released, `pad_oe` is all zero (every pin is an input), `pad_out` is all zero, and `bus_rdata` is zero.
- R2: The word address of bank b in a group is the group offset plus 4*b. The defaults are level 0x004, direction 0x01C, set 0x034 and clear 0x04C, with 6 banks of 32 pins. Bit k of bank b belongs to pin 32*b+k.
- R3: A write to the direction word of bank b loads the write data into the direction bits of pins 32*b..32*b+31, where 1 means output and 0 means input. `pad_oe` shows the new value from the clock edge that takes the write, and a read of the same word returns it. `pad_oe` changes only on a direction write.
- R4: A write to the set word makes every pin whose write-data bit is 1 drive high on `pad_out` from the clock edge that takes the write. Pins whose bit is 0 keep their latch value.
- R5: A write to the clear word makes every pin whose write-data bit is 1 drive low on `pad_out` from the clock edge that takes the write. Pins whose bit is 0 keep their latch value.
- R6: A read of any set or clear word returns 0.
- R7: A read of the level word of bank b returns `pad_in` for those 32 pins after the synchroniser, whatever their direction. A change on `pad_in` first appears in a read whose strobe is sampled on the third rising edge after the change (two synchroniser flops, then the read register).
- R8: Addresses outside the four groups, such as 0x000 or 0x064 and above with the defaults, and addresses that are not word aligned, read 0. Writes to them change no register.
- R9: `bus_rdata` loads the addressed word on a rising edge where `bus_rd` is high and holds its value on every other edge.
- R10: The output latch follows set and clear writes whatever the pin's direction, so `pad_out` of an input pin holds the value it will drive once it becomes an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W (12) | Byte address of the accessed word |
| bus_wr | input | 1 | Write strobe, one access per high cycle |
| bus_rd | input | 1 | Read strobe; data valid after the next rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NUM_PINS (192) | Asynchronous pad input levels |
| pad_out | output | NUM_PINS (192) | Output latch value per pin |
| pad_oe | output | NUM_PINS (192) | Output enable per pin (direction bit) |

## Verification
The latch is built up by a set with a sparse pattern, then a set with a disjoint pattern, then a clear that overlaps both. The resulting value tells a correct bitwise update apart from a plain overwrite or a missing mask. The direction and set words of banks 0, 3 and 5 are written with asymmetric values, so a fault in the bank stride or the group offsets lands in the wrong word, and this shows on the pad outputs and in readback. Distinct pad patterns per bank, read through the level words, separate the level readback from the latch, and a strobe held across a pad change pins the synchroniser depth to exactly two flops. Writes to the gap at 0x000, past the last group and at an unaligned address, each followed by reads of the direction word, show that undecoded accesses leave the state untouched.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int WORD_W = 32;

   typedef enum logic [2:0] {
      GRP_NONE  = 3'd0,
      GRP_LEVEL = 3'd1,
      GRP_DIR   = 3'd2,
      GRP_SET   = 3'd3,
      GRP_CLR   = 3'd4
   } grp_e;
endpackage

// File: rtl/gpio_sync_chain.sv
module gpio_sync_chain #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
   import gpio_bank_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int NUM_BANKS = 6,
   parameter int BANK_W    = 3,
   parameter int LVL_OFS   = 'h004,
   parameter int DIR_OFS   = 'h01C,
   parameter int SET_OFS   = 'h034,
   parameter int CLR_OFS   = 'h04C
) (
   input  logic [ADDR_W-1:0] addr,
   output grp_e              grp,
   output logic [BANK_W-1:0] bank
);
   localparam int SPAN = NUM_BANKS * 4;
   localparam int NGRP = 4;

   logic [NGRP-1:0] hit;
   logic [BANK_W-1:0] bsel [NGRP];

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      localparam int OFS = (g == 0) ? LVL_OFS :
                           (g == 1) ? DIR_OFS :
                           (g == 2) ? SET_OFS : CLR_OFS;
      logic [ADDR_W-1:0] diff;
      assign diff   = addr - ADDR_W'(OFS);
      assign hit[g] = (addr >= ADDR_W'(OFS)) && (diff < ADDR_W'(SPAN))
                      && (addr[1:0] == 2'b00);
      assign bsel[g] = diff[BANK_W+1:2];
   end

   always_comb begin
      grp  = GRP_NONE;
      bank = '0;
      if (hit[0]) begin
         grp  = GRP_LEVEL;
         bank = bsel[0];
      end else if (hit[1]) begin
         grp  = GRP_DIR;
         bank = bsel[1];
      end else if (hit[2]) begin
         grp  = GRP_SET;
         bank = bsel[2];
      end else if (hit[3]) begin
         grp  = GRP_CLR;
         bank = bsel[3];
      end
   end
endmodule

// File: rtl/gpio_bank_slice.sv
module gpio_bank_slice
   import gpio_bank_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_dir,
   input  logic              wr_set,
   input  logic              wr_clr,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] dir_q,
   output logic [WORD_W-1:0] lat_q
);
   logic [WORD_W-1:0] set_m, clr_m;

   assign set_m = wr_set ? wdata : '0;
   assign clr_m = wr_clr ? wdata : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         dir_q <= '0;
         lat_q <= '0;
      end else begin
         if (wr_dir) dir_q <= wdata;
         // clear dominates a set on the same bit
         lat_q <= (lat_q | set_m) & ~clr_m;
      end
   end
endmodule

// File: rtl/gpio_bank_port.sv
module gpio_bank_port
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS    = 192,
   parameter int ADDR_W      = 12,
   parameter int SYNC_STAGES = 2,
   parameter int LVL_OFS     = 'h004,
   parameter int DIR_OFS     = 'h01C,
   parameter int SET_OFS     = 'h034,
   parameter int CLR_OFS     = 'h04C
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [WORD_W-1:0]   bus_wdata,
   output logic [WORD_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe
);
   localparam int NUM_BANKS = NUM_PINS / WORD_W;
   localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
   localparam int SPAN      = NUM_BANKS * 4;

   // elaboration-time parameter checks
   if (NUM_PINS < WORD_W || (NUM_PINS % WORD_W) != 0) begin : g_bad_pins
      $error("NUM_PINS must be a non-zero multiple of 32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ADDR_W < BANK_W + 2) begin : g_bad_aw
      $error("ADDR_W too narrow for the bank index");
   end
   if ((LVL_OFS % 4) != 0 || (DIR_OFS % 4) != 0 ||
       (SET_OFS % 4) != 0 || (CLR_OFS % 4) != 0) begin : g_bad_align
      $error("group offsets must be word aligned");
   end
   if (LVL_OFS + SPAN > (1 << ADDR_W) || DIR_OFS + SPAN > (1 << ADDR_W) ||
       SET_OFS + SPAN > (1 << ADDR_W) || CLR_OFS + SPAN > (1 << ADDR_W)) begin : g_bad_range
      $error("a register group exceeds the address space");
   end
   for (genvar a = 0; a < 4; a++) begin : g_ovl_a
      for (genvar b = a + 1; b < 4; b++) begin : g_ovl_b
         localparam int OA = (a == 0) ? LVL_OFS : (a == 1) ? DIR_OFS :
                             (a == 2) ? SET_OFS : CLR_OFS;
         localparam int OB = (b == 0) ? LVL_OFS : (b == 1) ? DIR_OFS :
                             (b == 2) ? SET_OFS : CLR_OFS;
         if (OA < OB + SPAN && OB < OA + SPAN) begin : g_bad_ovl
            $error("register groups overlap");
         end
      end
   end

   grp_e              dec_grp;
   logic [BANK_W-1:0] dec_bank;
   logic [NUM_PINS-1:0] sync_q;
   logic [WORD_W-1:0] dir_w  [NUM_BANKS];
   logic [WORD_W-1:0] lat_w  [NUM_BANKS];
   logic [WORD_W-1:0] lvl_w  [NUM_BANKS];
   logic [WORD_W-1:0] rd_mux;

   gpio_addr_decode #(
      .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W),
      .LVL_OFS(LVL_OFS), .DIR_OFS(DIR_OFS), .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS)
   ) u_dec (
      .addr(bus_addr),
      .grp (dec_grp),
      .bank(dec_bank)
   );

   gpio_sync_chain #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk),
      .rst(rst),
      .d  (pad_in),
      .q  (sync_q)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic sel;
      assign sel = bus_wr && (dec_bank == BANK_W'(b));

      gpio_bank_slice u_slice (
         .clk   (clk),
         .rst   (rst),
         .wr_dir(sel && (dec_grp == GRP_DIR)),
         .wr_set(sel && (dec_grp == GRP_SET)),
         .wr_clr(sel && (dec_grp == GRP_CLR)),
         .wdata (bus_wdata),
         .dir_q (dir_w[b]),
         .lat_q (lat_w[b])
      );

      assign lvl_w[b] = sync_q[b*WORD_W +: WORD_W];
      assign pad_oe [b*WORD_W +: WORD_W] = dir_w[b];
      assign pad_out[b*WORD_W +: WORD_W] = lat_w[b];
   end

   always_comb begin
      rd_mux = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (dec_bank == BANK_W'(b)) begin
            case (dec_grp)
               GRP_LEVEL: rd_mux = lvl_w[b];
               GRP_DIR:   rd_mux = dir_w[b];
               default:   rd_mux = '0;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst)         bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end
endmodule

// File: rtl/gpio_bank_port_chk.sv
module gpio_bank_port_chk #(
   parameter int NUM_PINS    = 192,
   parameter int ADDR_W      = 12,
   parameter int SYNC_STAGES = 2,
   parameter int LVL_OFS     = 'h004,
   parameter int DIR_OFS     = 'h01C,
   parameter int SET_OFS     = 'h034,
   parameter int CLR_OFS     = 'h04C
) (
   input logic                clk,
   input logic                rst,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_wr,
   input logic                bus_rd,
   input logic [31:0]         bus_wdata,
   input logic [31:0]         bus_rdata,
   input logic [NUM_PINS-1:0] pad_out,
   input logic [NUM_PINS-1:0] pad_oe
);
   localparam int SPAN = (NUM_PINS / 32) * 4;

   logic in_set, in_clr;
   assign in_set = (bus_addr >= ADDR_W'(SET_OFS)) &&
                   (bus_addr < ADDR_W'(SET_OFS + SPAN));
   assign in_clr = (bus_addr >= ADDR_W'(CLR_OFS)) &&
                   (bus_addr < ADDR_W'(CLR_OFS + SPAN));

   assert_oe_hold_R3: assert property (@(posedge clk) disable iff (rst)
      !bus_wr |=> $stable(pad_oe));

   assert_set_bits_R4: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == ADDR_W'(SET_OFS)) |=>
      ((pad_out[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

   assert_clr_bits_R5: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == ADDR_W'(CLR_OFS)) |=>
      ((pad_out[31:0] & $past(bus_wdata)) == 32'd0));

   assert_out_hold_R5: assert property (@(posedge clk) disable iff (rst)
      !bus_wr |=> $stable(pad_out));

   assert_wo_read_zero_R6: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && (in_set || in_clr)) |=> (bus_rdata == 32'd0));

   assert_gap_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && bus_addr < ADDR_W'(LVL_OFS)) |=> (bus_rdata == 32'd0));

   assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !bus_rd |=> $stable(bus_rdata));
endmodule

bind gpio_bank_port gpio_bank_port_chk #(
   .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES),
   .LVL_OFS(LVL_OFS), .DIR_OFS(DIR_OFS), .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS)
) u_chk (
   .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/sim_gpio_bank_port.sv
`timescale 1ns/1ps
module sim_gpio_bank_port;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [11:0]  bus_addr = '0;
   logic         bus_wr = 1'b0;
   logic         bus_rd = 1'b0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic [191:0] pad_in = '0;
   logic [191:0] pad_out;
   logic [191:0] pad_oe;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   gpio_bank_port u0 (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   typedef struct packed {
      logic        rd;    // 1: read and compare, 0: write
      logic [11:0] addr;
      logic [31:0] data;  // write data or expected read data
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 12'h01C, 32'h0000_FFFF, 8'd3},  // R3 dir bank0
      '{1'b1, 12'h01C, 32'h0000_FFFF, 8'd3},  // R3 readback
      '{1'b0, 12'h034, 32'h0000_00F0, 8'd4},  // R4 set
      '{1'b0, 12'h034, 32'h0000_0003, 8'd4},  // R4 disjoint set
      '{1'b1, 12'h034, 32'h0000_0000, 8'd6},  // R6 set reads 0
      '{1'b0, 12'h04C, 32'h0000_0011, 8'd5},  // R5 clear overlaps
      '{1'b1, 12'h04C, 32'h0000_0000, 8'd6},  // R6 clear reads 0
      '{1'b0, 12'h030, 32'hA5A5_0000, 8'd2},  // R2 dir bank5
      '{1'b1, 12'h030, 32'hA5A5_0000, 8'd2},  // R2 readback bank5
      '{1'b1, 12'h020, 32'h0000_0000, 8'd2},  // R2 bank1 untouched
      '{1'b0, 12'h000, 32'hFFFF_FFFF, 8'd8},  // R8 gap write
      '{1'b1, 12'h000, 32'h0000_0000, 8'd8},  // R8 gap read
      '{1'b1, 12'h01C, 32'h0000_FFFF, 8'd8},  // R8 no side effect
      '{1'b0, 12'h064, 32'hFFFF_FFFF, 8'd8},  // R8 past last group
      '{1'b0, 12'h01E, 32'hFFFF_FFFF, 8'd8},  // R8 unaligned
      '{1'b1, 12'h01C, 32'h0000_FFFF, 8'd8},  // R8 still unchanged
      '{1'b0, 12'h040, 32'h8000_0001, 8'd10}  // R10 set bank3 (inputs)
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [11:0] a);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 during reset
      chk("R1 oe in reset", {31'd0, |pad_oe}, 32'd0);
      chk("R1 out in reset", {31'd0, |pad_out}, 32'd0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 oe after reset", {31'd0, |pad_oe}, 32'd0);
      chk("R1 rdata after reset", bus_rdata, 32'd0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].rd) begin
            bus_read(VEC[i].addr);
            chk($sformatf("R%0d vector %0d", VEC[i].req, i), bus_rdata, VEC[i].data);
         end else begin
            bus_write(VEC[i].addr, VEC[i].data);
         end
      end

      @(negedge clk);
      chk("R4 R5 latch bank0", pad_out[31:0], 32'h0000_00E2);
      chk("R3 oe bank0", pad_oe[31:0], 32'h0000_FFFF);
      chk("R2 oe bank5", pad_oe[191:160], 32'hA5A5_0000);
      chk("R10 latch bank3 as input", pad_out[127:96], 32'h8000_0001);
      chk("R2 oe bank3 input", pad_oe[127:96], 32'd0);
      chk("R8 latch bank1 untouched", pad_out[63:32], 32'd0);

      // R7 level readback on mixed-direction bank0 and on bank5
      pad_in[31:0]    = 32'h1234_5678;
      pad_in[191:160] = 32'hCAFE_F00D;
      repeat (4) @(negedge clk);
      bus_read(12'h004);
      chk("R7 level bank0", bus_rdata, 32'h1234_5678);
      bus_read(12'h018);
      chk("R7 R2 level bank5", bus_rdata, 32'hCAFE_F00D);

      // R7 latency: strobe held across a pad change on bank2
      @(negedge clk);
      bus_addr = 12'h00C; bus_rd = 1'b1;
      pad_in[95:64] = 32'h0F0F_0F0F;
      @(negedge clk);
      chk("R7 edge1 old", bus_rdata, 32'd0);
      @(negedge clk);
      chk("R7 edge2 old", bus_rdata, 32'd0);
      @(negedge clk);
      chk("R7 edge3 new", bus_rdata, 32'h0F0F_0F0F);
      bus_rd = 1'b0;

      // R9 hold without strobe
      pad_in[95:64] = 32'hFFFF_FFFF;
      repeat (4) @(negedge clk);
      bus_write(12'h020, 32'h1111_1111);
      chk("R9 rdata held", bus_rdata, 32'h0F0F_0F0F);

      // R5 clear of a bank3 bit only
      bus_write(12'h058, 32'h0000_0001);
      @(negedge clk);
      chk("R5 bank3 clear", pad_out[127:96], 32'h8000_0000);

      // R1 reset mid-run
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 oe after rerun", {31'd0, |pad_oe}, 32'd0);
      chk("R1 out after rerun", {31'd0, |pad_out}, 32'd0);
      chk("R1 rdata after rerun", bus_rdata, 32'd0);
      bus_read(12'h01C);
      chk("R1 dir word after rerun", bus_rdata, 32'd0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule